// File: doc/BRIEF.md
# Fractional Fixed-Point Clock Divider

This block derives a slower clock from one input clock. The divide ratio is fixed at elaboration from two frequency parameters: the input clock rate and the wanted output rate. The block holds the half-period of the output, measured in input cycles, as a fixed-point number with 16 fraction bits and up to 24 integer bits. A phase accumulator steps through that half-period one input cycle at a time. It carries the leftover fraction from one half-period into the next. Because of this, non-integer ratios keep the right average frequency, and each edge lands within one input cycle of its ideal position.

The outputs are a square wave with a nominal 50:50 duty cycle and two single-cycle strobes in the input clock domain. One strobe marks the cycle in which the square wave goes high, and the other marks the cycle in which it goes low. Logic that stays in the input clock domain can use the strobes as clock enables. A parameter chooses between fractional division and integer-only division. In integer-only mode the half-period is rounded to a whole number of input cycles, and a plain down-counter replaces the accumulator.

Elaboration stops with an error when the requested output rate is zero or above half the input rate, or when the integer part of the ratio needs more than 24 bits. The integer field is always at least 2 bits wide, even for the smallest ratios.

Top module: `fp_clk_divider`

## Requirements
- R1: In fractional mode the half-period ratio H equals round(CLK_IN_HZ * 65536 / (2 * CLK_OUT_HZ)), a value with 16 fraction bits.
- R2: In integer-only mode H equals round(CLK_IN_HZ / (2 * CLK_OUT_HZ)) * 65536, so every half-period is a whole number of input cycles.
- R3: Number the rising input-clock edges after reset release from 1, where edge 1 is the first one at which rst is sampled low. The k-th change of clk_out happens at edge floor(k * H / 65536).
- R4: clk_out starts low after reset, changes only at the edges given by R3, and is high after every odd-numbered change. The count of rise strobes equals the number of odd-numbered changes.
- R5: rise_stb is high for exactly the one input cycle in which clk_out has just gone from 0 to 1.
- R6: fall_stb is high for exactly the one input cycle in which clk_out has just gone from 1 to 0.
- R7: rise_stb and fall_stb are never high in the same cycle.
- R8: The reset is synchronous and active high. While it is sampled high, clk_out, rise_stb and fall_stb are all low. Releasing it, even in the middle of an output period, restarts the R3 edge timing from edge 1.
- R9: The highest rate, an output at half the input rate (H = 1.0), makes clk_out change on every input cycle. A ratio of H = 1.5 makes changes alternate between gaps of 1 and 2 cycles. Both work with the 2-bit minimum integer field.
- R10: Large ratios that need many integer bits, for example 50 MHz in and 1.5 kHz out (H of about 16666.67), follow R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_out | output | 1 | Divided square-wave clock |
| rise_stb | output | 1 | One-cycle strobe in the cycle clk_out goes high |
| fall_stb | output | 1 | One-cycle strobe in the cycle clk_out goes low |

## Verification
The hardest behaviour to reach from the ports is how the carried fraction builds up. An edge that falls one cycle early or late shows up only after many half-periods, and with a large ratio the first edge comes only after thousands of cycles. The bench therefore runs several instances with different ratios: the two example frequency pairs, the rate limits H = 1.0 and H = 1.5, and a ratio of about 16667. For each instance it predicts the exact edge number of every output change from floor(k * H) and compares edge by edge. It also resets each instance while it is mid-period to show that the timing restarts cleanly.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;

    // Half output period in input cycles, fixed point with frac_w fraction bits.
    function automatic longint half_ratio(input longint fin, input longint fout,
                                          input int frac_w, input bit frac_mode);
        longint one;
        one = longint'(1) << frac_w;
        if (fout <= 0 || 2 * fout > fin)
            return one;
        if (frac_mode)
            return ((fin << frac_w) + fout) / (2 * fout);
        return ((fin + fout) / (2 * fout)) << frac_w;
    endfunction

    // Integer bits the accumulator needs: it must hold a value below H + 1.0.
    function automatic int whole_bits(input longint half, input int frac_w);
        longint span;
        int     b;
        span = (half >> frac_w) + 2;
        b = $clog2(span);
        return (b < 2) ? 2 : b;
    endfunction

endpackage

// File: rtl/fpdiv_phase.sv
module fpdiv_phase #(
    parameter int              FRAC_W     = 16,
    parameter int              ACC_W      = 18,
    parameter bit              FRACTIONAL = 1'b1,
    parameter logic [ACC_W-1:0] HALF      = 18'h10000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int WHOLE_W = ACC_W - FRAC_W;
    localparam logic [ACC_W-1:0] ONE = {{(WHOLE_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    if (FRACTIONAL) begin : g_frac
        typedef struct packed {
            logic [ACC_W-1:0] acc;
        } phase_t;

        phase_t           ph_q, ph_d;
        logic [ACC_W-1:0] rem_d;
        logic             fire_d;

        always_comb begin
            ph_d   = ph_q;
            rem_d  = ph_q.acc - ONE;
            fire_d = (rem_d < ONE);
            if (fire_d)
                ph_d.acc = rem_d + HALF;
            else
                ph_d.acc = rem_d;
        end

        always_ff @(posedge clk) begin
            if (rst)
                ph_q.acc <= HALF;
            else
                ph_q <= ph_d;
        end

        assign tick = fire_d;

        // R3: the remainder never falls below one whole input cycle
        a_r3_acc_floor: assert property (@(posedge clk) disable iff (rst)
            seen_q |-> (ph_q.acc >= ONE));
        // R3: the remainder stays below H + 1.0 so nothing wraps
        a_r3_acc_ceiling: assert property (@(posedge clk) disable iff (rst)
            seen_q |-> ({1'b0, ph_q.acc} < ({1'b0, HALF} + {1'b0, ONE})));
    end else begin : g_int
        localparam logic [WHOLE_W-1:0] H_WHOLE = HALF[ACC_W-1:FRAC_W];
        localparam logic [WHOLE_W-1:0] CNT_ONE = {{(WHOLE_W-1){1'b0}}, 1'b1};

        typedef struct packed {
            logic [WHOLE_W-1:0] cnt;
        } count_t;

        count_t cn_q, cn_d;
        logic   fire_d;

        always_comb begin
            cn_d   = cn_q;
            fire_d = (cn_q.cnt == CNT_ONE);
            if (fire_d)
                cn_d.cnt = H_WHOLE;
            else
                cn_d.cnt = cn_q.cnt - CNT_ONE;
        end

        always_ff @(posedge clk) begin
            if (rst)
                cn_q.cnt <= H_WHOLE;
            else
                cn_q <= cn_d;
        end

        assign tick = fire_d;

        // R2: the whole-cycle counter stays within 1..H
        a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
            seen_q |-> (cn_q.cnt >= CNT_ONE && cn_q.cnt <= H_WHOLE));
        // R2: the counter reloads one edge after it reaches 1
        a_r2_reload: assert property (@(posedge clk) disable iff (rst)
            seen_q && cn_q.cnt == CNT_ONE |=> cn_q.cnt == H_WHOLE);
    end

endmodule

// File: rtl/fpdiv_edge.sv
module fpdiv_edge
    import fpdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic clk_out,
    output logic rise_stb,
    output logic fall_stb
);

    typedef struct packed {
        logic  level;
        edge_e kind;
    } wave_t;

    wave_t wv_q, wv_d;

    always_comb begin
        wv_d      = wv_q;
        wv_d.kind = EDGE_NONE;
        if (tick) begin
            wv_d.level = ~wv_q.level;
            wv_d.kind  = wv_q.level ? EDGE_FALL : EDGE_RISE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wv_q.level <= 1'b0;
            wv_q.kind  <= EDGE_NONE;
        end else begin
            wv_q <= wv_d;
        end
    end

    assign clk_out  = wv_q.level;
    assign rise_stb = (wv_q.kind == EDGE_RISE);
    assign fall_stb = (wv_q.kind == EDGE_FALL);

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R7: the strobes are mutually exclusive
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));
    // R5: a rise strobe sits on a fresh 0 -> 1 transition
    a_r5_rise_edge: assert property (@(posedge clk) disable iff (rst)
        seen_q && rise_stb |-> clk_out && !$past(clk_out));
    // R6: a fall strobe sits on a fresh 1 -> 0 transition
    a_r6_fall_edge: assert property (@(posedge clk) disable iff (rst)
        seen_q && fall_stb |-> !clk_out && $past(clk_out));
    // R8: one edge after reset is sampled, every output is low
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!seen_q)
        $past(rst) |-> !clk_out && !rise_stb && !fall_stb);

endmodule

// File: rtl/fp_clk_divider.sv
module fp_clk_divider
    import fpdiv_pkg::*;
#(
    parameter longint CLK_IN_HZ  = 100_000_000,
    parameter longint CLK_OUT_HZ = 3_579_545,
    parameter bit     FRACTIONAL = 1'b1,
    parameter int     INT_W      = 24,
    parameter int     FRAC_W     = 16
) (
    input  logic clk,
    input  logic rst,
    output logic clk_out,
    output logic rise_stb,
    output logic fall_stb
);

    localparam longint HALF_L = half_ratio(CLK_IN_HZ, CLK_OUT_HZ, FRAC_W, FRACTIONAL);
    localparam int     IBITS  = whole_bits(HALF_L, FRAC_W);
    localparam int     ACC_W  = FRAC_W + IBITS;
    localparam logic [ACC_W-1:0] HALF = HALF_L[ACC_W-1:0];

    if (CLK_OUT_HZ <= 0 || 2 * CLK_OUT_HZ > CLK_IN_HZ) begin : g_bad_rate
        $error("fp_clk_divider: output rate must be positive and at most half the input rate");
    end
    if (IBITS > INT_W) begin : g_bad_width
        $error("fp_clk_divider: divide ratio needs more integer bits than INT_W allows");
    end

    logic tick;

    fpdiv_phase #(
        .FRAC_W     (FRAC_W),
        .ACC_W      (ACC_W),
        .FRACTIONAL (FRACTIONAL),
        .HALF       (HALF)
    ) u_phase (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    fpdiv_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .clk_out  (clk_out),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    logic seen_q;
    always_ff @(posedge clk) seen_q <= 1'b1;

    // R4: the output changes one edge after the accumulator fires
    a_r4_toggle_on_tick: assert property (@(posedge clk) disable iff (rst)
        seen_q && tick |=> clk_out != $past(clk_out));
    // R4: the output holds when the accumulator does not fire
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        seen_q && !tick |=> $stable(clk_out));

endmodule

// File: tb/sim_fp_clk_divider.sv
module sim_fp_clk_divider;

    localparam int NI = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    wire [NI-1:0] co, rs, fs;

    int checks = 0;
    int fails  = 0;

    // u0: 100 MHz -> 3.579545 MHz, fractional
    fp_clk_divider #(.CLK_IN_HZ(100_000_000), .CLK_OUT_HZ(3_579_545), .FRACTIONAL(1'b1)) u0
        (.clk(clk), .rst(rst), .clk_out(co[0]), .rise_stb(rs[0]), .fall_stb(fs[0]));
    // u1: same rates, integer-only
    fp_clk_divider #(.CLK_IN_HZ(100_000_000), .CLK_OUT_HZ(3_579_545), .FRACTIONAL(1'b0)) u1
        (.clk(clk), .rst(rst), .clk_out(co[1]), .rise_stb(rs[1]), .fall_stb(fs[1]));
    // u2: 148.5 MHz -> 3.072 MHz, fractional
    fp_clk_divider #(.CLK_IN_HZ(148_500_000), .CLK_OUT_HZ(3_072_000), .FRACTIONAL(1'b1)) u2
        (.clk(clk), .rst(rst), .clk_out(co[2]), .rise_stb(rs[2]), .fall_stb(fs[2]));
    // u3: H = 1.0
    fp_clk_divider #(.CLK_IN_HZ(2), .CLK_OUT_HZ(1), .FRACTIONAL(1'b1)) u3
        (.clk(clk), .rst(rst), .clk_out(co[3]), .rise_stb(rs[3]), .fall_stb(fs[3]));
    // u4: H = 1.5
    fp_clk_divider #(.CLK_IN_HZ(3), .CLK_OUT_HZ(1), .FRACTIONAL(1'b1)) u4
        (.clk(clk), .rst(rst), .clk_out(co[4]), .rise_stb(rs[4]), .fall_stb(fs[4]));
    // u5: large ratio
    fp_clk_divider #(.CLK_IN_HZ(50_000_000), .CLK_OUT_HZ(1_500), .FRACTIONAL(1'b1)) u5
        (.clk(clk), .rst(rst), .clk_out(co[5]), .rise_stb(rs[5]), .fall_stb(fs[5]));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint frac_half(input longint fin, input longint fout);
        return (fin * 65536 + fout) / (2 * fout);
    endfunction

    function automatic longint int_half(input longint fin, input longint fout);
        return ((fin + fout) / (2 * fout)) * 65536;
    endfunction

    // R8: hold reset and confirm every instance is quiet
    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            chk(co[i] == 1'b0 && rs[i] == 1'b0 && fs[i] == 1'b0, "R8", "outputs low in reset",
                longint'({co[i], rs[i], fs[i]}), 0);
        end
        rst = 1'b0;
    endtask

    // R3..R7: edge-exact comparison of one instance against floor(k*H)
    task automatic run_case(input int idx, input longint half, input int ncyc, input string req);
        logic   prev;
        longint k;
        longint rises;
        longint toggles;
        int     bad;
        prev = 1'b0;
        k = 1;
        rises = 0;
        toggles = 0;
        bad = 0;
        apply_reset();
        for (int c = 1; c <= ncyc; c++) begin
            logic   lvl, r, f, moved, due;
            longint want;
            @(negedge clk);
            lvl   = co[idx];
            r     = rs[idx];
            f     = fs[idx];
            moved = (lvl != prev);
            want  = (k * half) >> 16;
            due   = (longint'(c) == want);
            if (bad < 8) begin
                chk(moved == due, req, $sformatf("u%0d change at edge %0d", idx, c),
                    longint'(moved), longint'(due));
                chk(r == (lvl && !prev), "R5", $sformatf("u%0d rise strobe edge %0d", idx, c),
                    longint'(r), longint'(lvl && !prev));
                chk(f == (!lvl && prev), "R6", $sformatf("u%0d fall strobe edge %0d", idx, c),
                    longint'(f), longint'(!lvl && prev));
                chk(!(r && f), "R7", $sformatf("u%0d both strobes edge %0d", idx, c),
                    longint'({r, f}), 0);
                if (moved != due || r != (lvl && !prev) || f != (!lvl && prev))
                    bad++;
            end
            if (moved) toggles++;
            if (r) rises++;
            if (due) k++;
            prev = lvl;
        end
        chk(toggles == k - 1, "R3", $sformatf("u%0d change count", idx), toggles, k - 1);
        chk(rises == k / 2, "R4", $sformatf("u%0d rise count", idx), rises, k / 2);
    endtask

    task automatic test_frac_example_a();
        run_case(0, frac_half(100_000_000, 3_579_545), 3000, "R1");
    endtask

    task automatic test_int_mode();
        run_case(1, int_half(100_000_000, 3_579_545), 3000, "R2");
    endtask

    task automatic test_frac_example_b();
        run_case(2, frac_half(148_500_000, 3_072_000), 3000, "R3");
    endtask

    task automatic test_max_rate();
        run_case(3, frac_half(2, 1), 200, "R9");
        run_case(4, frac_half(3, 1), 200, "R9");
    endtask

    task automatic test_large_ratio();
        run_case(5, frac_half(50_000_000, 1_500), 40000, "R10");
    endtask

    // R8: a reset in the middle of a period restarts timing from edge 1
    task automatic test_mid_reset();
        apply_reset();
        repeat (37) @(negedge clk);
        run_case(2, frac_half(148_500_000, 3_072_000), 600, "R8");
    endtask

    // R4: starts low and stays low before the first change
    task automatic test_start_low();
        apply_reset();
        @(negedge clk);
        chk(co[0] == 1'b0, "R4", "u0 low on first edge", longint'(co[0]), 0);
        chk(co[5] == 1'b0 && rs[5] == 1'b0, "R4", "u5 idle on first edge",
            longint'({co[5], rs[5]}), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        repeat (2) @(negedge clk);
        test_start_low();
        test_frac_example_a();
        test_int_mode();
        test_frac_example_b();
        test_max_rate();
        test_mid_reset();
        test_large_ratio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule